// File: doc/BRIEF.md
# Three-Wire Serial Register Interface

This block is the slave side of a three-wire serial bus made of an enable line, a serial clock and one bidirectional data line. The data line appears here as an input, an output and an output-enable, which the pad ring combines. The serial clock and the enable arrive already synchronized into the system clock domain, so every serial edge is detected inside the block as a one-cycle event.

Each transfer opens with a command byte. The command selects the clock bank or the RAM bank, gives an address, and chooses read or write. The engine then runs a single-byte access or a burst. The clock bank has eight burst-reachable registers: seven time registers and a control register that carries the write-protect flag. A charger register sits beside them and is reachable only by a single-byte access. The RAM bank holds 31 bytes.

The register storage and the time counters are outside this block. The engine reaches them through three paths:
- a combinational read port;
- a one-byte write port;
- a wide port that commits a whole clock-bank burst in one cycle.

At the start of a clock burst read, the engine captures the current time into a private shadow and pulses a snapshot output.

Top module: `tw_serial_regif`

## Requirements
- R1: While the enable is low, the output-enable is 0 and any transfer in progress is abandoned, so a partial command or data byte causes no write.
- R2: The command byte arrives LSB first. Bit 0 = 1 means read and 0 means write. Bits 5..1 hold the address. Bit 6 = 1 selects the RAM bank and 0 selects the clock bank. If bit 7 is 0, no write of any kind happens.
- R3: Input bits are sampled on rising serial-clock edges. Output bits change on falling edges. The output-enable goes to 0 after every rising edge and back to 1 on the next falling edge of a read.
- R4: In a read, data bit 0 is driven on the first falling edge after the eighth command bit, and each data byte is sent LSB first.
- R5: A single-byte read keeps re-sending the same byte for as long as the enable stays high. A single-byte write performs exactly one write, and clocks after its eighth data bit are ignored.
- R6: Address 31 selects burst mode in either bank, and a burst begins at address 0.
- R7: A clock-bank burst write commits registers 0..7 together, in a single cycle on the wide port, after the eighth byte arrives. With fewer than eight bytes nothing is written. Bytes after the eighth are ignored.
- R8: A RAM burst write commits each byte to RAM addresses 0, 1, 2 and so on as soon as that byte completes, for at most 31 bytes. Later bytes are ignored.
- R9: While write-protect is 1, the only write the engine issues is a single-byte write to clock register 7. A clock burst write performs no write at all, including the control register.
- R10: A clock burst read captures the time bus when the command completes and pulses the snapshot output for one cycle. Bytes 0..6 then come from that capture, and byte 7 is the live control register.
- R11: The charger register at clock address 8 is reachable only by single-byte reads and writes. A clock burst never writes it, and the ninth and later bytes of a clock burst read are 0.
- R12: Clock addresses 9..30 and RAM address 31 hold no storage. Reads from them return 0 whatever the read port supplies, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_i | input | 1 | Transfer enable, synchronized, high during a transfer |
| sclk_i | input | 1 | Serial clock, synchronized |
| sdi_i | input | 1 | Serial data from the pad |
| sdo_o | output | 1 | Serial data to the pad |
| sdo_oe_o | output | 1 | Pad output enable; 0 leaves the line in high impedance |
| rd_ram_o | output | 1 | Read port bank select (1 = RAM) |
| rd_addr_o | output | 5 | Read port address |
| rd_data_i | input | 8 | Read port data, combinational from storage |
| wr_en_o | output | 1 | One-cycle single-byte write strobe |
| wr_ram_o | output | 1 | Write bank select (1 = RAM) |
| wr_addr_o | output | 5 | Write address |
| wr_data_o | output | 8 | Write data |
| bulk_we_o | output | 1 | One-cycle commit of a full clock-bank burst |
| bulk_data_o | output | CLK_REGS*8 | Burst bytes, register k in bits 8k+7..8k |
| wp_i | input | 1 | Write-protect flag from control register 7 |
| time_i | input | (CLK_REGS-1)*8 | Live time registers, register k in bits 8k+7..8k |
| snap_o | output | 1 | One-cycle pulse when the time is captured |

## Verification
The bench builds the block with its default sizes: eight clock-bank registers, a charger at address 8, and 31 RAM bytes. With these sizes a full RAM burst, its overrun past 31 bytes and the read of unstored RAM address 31 all fit in a few thousand cycles. The bench's storage model returns a marker value for unstored addresses, so a missing zero-gate in the engine shows up at the data line. The bench also changes a time register after the snapshot and before data goes out, which separates captured bytes from live ones.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  localparam int          CMD_W      = 8;
  localparam int          ADDR_W     = 5;
  localparam logic [4:0]  BURST_ADDR = 5'h1F;

  typedef struct packed {
    logic              en;    // must be 1 for any write
    logic              ram;   // bank select
    logic [ADDR_W-1:0] addr;
    logic              rd;    // 1 = read
  } cmd_t;

  typedef enum logic [1:0] {
    XF_SINGLE    = 2'd0,
    XF_CLK_BURST = 2'd1,
    XF_RAM_BURST = 2'd2
  } xfer_e;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/tw_edge_det.sv
`timescale 1ns/1ps
module tw_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/tw_cmd_decode.sv
`timescale 1ns/1ps
module tw_cmd_decode
  import tw_pkg::*;
(
  input  logic [CMD_W-1:0] raw_i,
  output cmd_t             cmd_o,
  output xfer_e            kind_o
);
  assign cmd_o = '{en: raw_i[7], ram: raw_i[6], addr: raw_i[5:1], rd: raw_i[0]};

  always_comb begin
    if (raw_i[5:1] != BURST_ADDR) kind_o = XF_SINGLE;
    else if (raw_i[6])            kind_o = XF_RAM_BURST;
    else                          kind_o = XF_CLK_BURST;
  end
endmodule

// File: rtl/tw_rd_select.sv
`timescale 1ns/1ps
module tw_rd_select
  import tw_pkg::*;
#(
  parameter int CLK_REGS  = 8,
  parameter int CHG_ADDR  = 8,
  parameter int RAM_BYTES = 31
) (
  input  xfer_e                     kind_i,
  input  cmd_t                      cmd_i,
  input  logic [ADDR_W-1:0]         idx_i,
  input  logic [(CLK_REGS-1)*8-1:0] shadow_i,
  input  logic [7:0]                rd_data_i,
  output logic [ADDR_W-1:0]         rd_addr_o,
  output logic [7:0]                byte_o
);
  localparam int         TIME_REGS = CLK_REGS - 1;
  localparam logic [4:0] CTRL_A    = 5'(CLK_REGS - 1);
  localparam logic [4:0] CHG_A     = 5'(CHG_ADDR);
  localparam logic [4:0] RAM_LAST  = 5'(RAM_BYTES - 1);

  logic [7:0] shadow_byte;

  always_comb begin
    shadow_byte = 8'h00;
    for (int k = 0; k < TIME_REGS; k++)
      if (idx_i == 5'(k)) shadow_byte = shadow_i[k*8 +: 8];
  end

  assign rd_addr_o = (kind_i == XF_SINGLE) ? cmd_i.addr : idx_i;

  always_comb begin
    byte_o = 8'h00;
    unique case (kind_i)
      XF_CLK_BURST: begin
        if (idx_i < CTRL_A)       byte_o = shadow_byte;
        else if (idx_i == CTRL_A) byte_o = rd_data_i;
      end
      XF_RAM_BURST: if (idx_i <= RAM_LAST) byte_o = rd_data_i;
      default: begin
        if (cmd_i.ram ? (cmd_i.addr <= RAM_LAST) : (cmd_i.addr <= CHG_A))
          byte_o = rd_data_i;
      end
    endcase
  end
endmodule

// File: rtl/tw_serial_regif.sv
`timescale 1ns/1ps
module tw_serial_regif
  import tw_pkg::*;
#(
  parameter int CLK_REGS  = 8,
  parameter int CHG_ADDR  = 8,
  parameter int RAM_BYTES = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_i,
  input  logic                      sclk_i,
  input  logic                      sdi_i,
  output logic                      sdo_o,
  output logic                      sdo_oe_o,
  output logic                      rd_ram_o,
  output logic [4:0]                rd_addr_o,
  input  logic [7:0]                rd_data_i,
  output logic                      wr_en_o,
  output logic                      wr_ram_o,
  output logic [4:0]                wr_addr_o,
  output logic [7:0]                wr_data_o,
  output logic                      bulk_we_o,
  output logic [CLK_REGS*8-1:0]     bulk_data_o,
  input  logic                      wp_i,
  input  logic [(CLK_REGS-1)*8-1:0] time_i,
  output logic                      snap_o
);
  localparam int         BULK_W   = CLK_REGS * 8;
  localparam int         TIME_W   = (CLK_REGS - 1) * 8;
  localparam logic [4:0] CTRL_A   = 5'(CLK_REGS - 1);
  localparam logic [4:0] CHG_A    = 5'(CHG_ADDR);
  localparam logic [4:0] RAM_LAST = 5'(RAM_BYTES - 1);
  localparam logic [4:0] CLK_LIM  = 5'(CLK_REGS);
  localparam logic [4:0] RAM_LIM  = 5'(RAM_BYTES);

  logic sck_rise, sck_fall;
  tw_edge_det u_edge (.clk(clk), .rst_n(rst_n), .lvl_i(sclk_i), .rise_o(sck_rise), .fall_o(sck_fall));

  phase_e            ph_q, ph_n;
  logic [2:0]        bit_q, bit_n;
  logic [4:0]        idx_q, idx_n;
  logic [7:0]        cmd_raw_q, cmd_raw_n, cmd_shift;
  logic [7:0]        rx_q, rx_n, tx_q, tx_n;
  logic              sdo_q, sdo_n, oe_q, oe_n;
  logic [BULK_W-1:0] wbuf_q, wbuf_n;
  logic [TIME_W-1:0] shadow_q, shadow_n;
  logic              wr_en_q, wr_en_n, wr_ram_q, wr_ram_n;
  logic [4:0]        wr_addr_q, wr_addr_n;
  logic [7:0]        wr_data_q, wr_data_n;
  logic              bulk_q, bulk_n, snap_q, snap_n;

  cmd_t       cur;
  xfer_e      kind;
  logic [4:0] lim;
  logic [7:0] rd_byte;
  logic       single_ok, is_clk_burst_rd;

  tw_cmd_decode u_dec (.raw_i(cmd_raw_q), .cmd_o(cur), .kind_o(kind));

  tw_rd_select #(.CLK_REGS(CLK_REGS), .CHG_ADDR(CHG_ADDR), .RAM_BYTES(RAM_BYTES)) u_rsel (
    .kind_i(kind), .cmd_i(cur), .idx_i(idx_q), .shadow_i(shadow_q),
    .rd_data_i(rd_data_i), .rd_addr_o(rd_addr_o), .byte_o(rd_byte)
  );

  assign cmd_shift       = {sdi_i, cmd_raw_q[7:1]};
  assign is_clk_burst_rd = cmd_shift[0] & ~cmd_shift[6] & (cmd_shift[5:1] == BURST_ADDR);

  always_comb begin
    unique case (kind)
      XF_SINGLE:    lim = 5'd1;
      XF_CLK_BURST: lim = CLK_LIM;
      default:      lim = RAM_LIM;
    endcase
  end

  assign single_ok = cur.en
                   & (cur.ram ? (cur.addr <= RAM_LAST) : (cur.addr <= CHG_A))
                   & (~wp_i | (~cur.ram & (cur.addr == CTRL_A)));

  // next-state process
  always_comb begin
    ph_n = ph_q;  bit_n = bit_q;  idx_n = idx_q;  cmd_raw_n = cmd_raw_q;
    rx_n = rx_q;  tx_n = tx_q;    sdo_n = sdo_q;  oe_n = oe_q;
    wbuf_n = wbuf_q;  shadow_n = shadow_q;
    wr_en_n = 1'b0;   wr_ram_n = wr_ram_q;  wr_addr_n = wr_addr_q;  wr_data_n = wr_data_q;
    bulk_n = 1'b0;    snap_n = 1'b0;
    if (!sel_i) begin
      ph_n = PH_CMD; bit_n = 3'd0; idx_n = 5'd0; cmd_raw_n = 8'h00;
      oe_n = 1'b0;   sdo_n = 1'b0;
    end else if (sck_rise) begin
      oe_n = 1'b0;
      if (ph_q == PH_CMD) begin
        cmd_raw_n = cmd_shift;
        bit_n     = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          ph_n  = PH_DATA;
          idx_n = 5'd0;
          if (is_clk_burst_rd) begin
            shadow_n = time_i;
            snap_n   = 1'b1;
          end
        end
      end else if (!cur.rd) begin
        rx_n  = {sdi_i, rx_q[7:1]};
        bit_n = bit_q + 3'd1;
        if (bit_q == 3'd7 && idx_q < lim) begin
          idx_n = idx_q + 5'd1;
          unique case (kind)
            XF_SINGLE: if (single_ok) begin
              wr_en_n = 1'b1; wr_ram_n = cur.ram; wr_addr_n = cur.addr; wr_data_n = rx_n;
            end
            XF_RAM_BURST: if (cur.en && !wp_i) begin
              wr_en_n = 1'b1; wr_ram_n = 1'b1; wr_addr_n = idx_q; wr_data_n = rx_n;
            end
            default: begin
              for (int k = 0; k < CLK_REGS; k++)
                if (idx_q == 5'(k)) wbuf_n[k*8 +: 8] = rx_n;
              if (idx_q == CTRL_A && cur.en && !wp_i) bulk_n = 1'b1;
            end
          endcase
        end
      end
    end else if (sck_fall && ph_q == PH_DATA && cur.rd) begin
      oe_n  = 1'b1;
      bit_n = bit_q + 3'd1;
      if (bit_q == 3'd0) begin
        tx_n  = rd_byte;
        sdo_n = rd_byte[0];
      end else begin
        sdo_n = tx_q[bit_q];
      end
      if (bit_q == 3'd7 && kind != XF_SINGLE && idx_q != 5'h1F) idx_n = idx_q + 5'd1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_CMD;  bit_q <= 3'd0;  idx_q <= 5'd0;  cmd_raw_q <= 8'h00;
      rx_q <= 8'h00;   tx_q <= 8'h00;  sdo_q <= 1'b0;  oe_q <= 1'b0;
      wbuf_q <= '0;    shadow_q <= '0;
      wr_en_q <= 1'b0; wr_ram_q <= 1'b0; wr_addr_q <= 5'd0; wr_data_q <= 8'h00;
      bulk_q <= 1'b0;  snap_q <= 1'b0;
    end else begin
      ph_q <= ph_n;    bit_q <= bit_n;  idx_q <= idx_n;  cmd_raw_q <= cmd_raw_n;
      rx_q <= rx_n;    tx_q <= tx_n;    sdo_q <= sdo_n;  oe_q <= oe_n;
      wbuf_q <= wbuf_n; shadow_q <= shadow_n;
      wr_en_q <= wr_en_n; wr_ram_q <= wr_ram_n; wr_addr_q <= wr_addr_n; wr_data_q <= wr_data_n;
      bulk_q <= bulk_n; snap_q <= snap_n;
    end
  end

  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = oe_q;
  assign rd_ram_o    = cur.ram;
  assign wr_en_o     = wr_en_q;
  assign wr_ram_o    = wr_ram_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign bulk_we_o   = bulk_q;
  assign bulk_data_o = wbuf_q;
  assign snap_o      = snap_q;
endmodule

// File: rtl/tw_serial_regif_chk.sv
`timescale 1ns/1ps
module tw_serial_regif_chk #(
  parameter int CLK_REGS  = 8,
  parameter int CHG_ADDR  = 8,
  parameter int RAM_BYTES = 31
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_i,
  input logic       sclk_i,
  input logic       sdo_oe_o,
  input logic       wr_en_o,
  input logic       wr_ram_o,
  input logic [4:0] wr_addr_o,
  input logic       bulk_we_o,
  input logic       wp_i,
  input logic       snap_o
);
  localparam logic [4:0] CTRL_A   = 5'(CLK_REGS - 1);
  localparam logic [4:0] CHG_A    = 5'(CHG_ADDR);
  localparam logic [4:0] RAM_LAST = 5'(RAM_BYTES - 1);

  // R1
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !sdo_oe_o);

  // R3
  release_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sclk_i) && !$past(sclk_i, 2)) |-> !sdo_oe_o);

  // R3
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> (!$past(sclk_i) && $past(sclk_i, 2)));

  // R9
  protect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (!$past(wp_i) || (!wr_ram_o && wr_addr_o == CTRL_A)));

  // R9
  protect_bulk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_we_o |-> !$past(wp_i));

  // R7
  one_commit_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_o, bulk_we_o}));

  // R12
  stored_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_ram_o ? (wr_addr_o <= RAM_LAST) : (wr_addr_o <= CHG_A)));

  // R10
  snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_o |=> !snap_o);
endmodule

bind tw_serial_regif tw_serial_regif_chk #(
  .CLK_REGS(CLK_REGS), .CHG_ADDR(CHG_ADDR), .RAM_BYTES(RAM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i), .sdo_oe_o(sdo_oe_o),
  .wr_en_o(wr_en_o), .wr_ram_o(wr_ram_o), .wr_addr_o(wr_addr_o),
  .bulk_we_o(bulk_we_o), .wp_i(wp_i), .snap_o(snap_o)
);

// File: tb/tw_serial_regif_tb.sv
`timescale 1ns/1ps
module tw_serial_regif_tb;
  localparam int CLK_REGS  = 8;
  localparam int CHG_ADDR  = 8;
  localparam int RAM_BYTES = 31;
  localparam int H         = 4;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, rd_ram, wr_en, wr_ram, bulk_we, wp, snap;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [CLK_REGS*8-1:0]     bulk_data;
  logic [(CLK_REGS-1)*8-1:0] time_bus;

  always #2.5 clk = ~clk;

  tw_serial_regif #(.CLK_REGS(CLK_REGS), .CHG_ADDR(CHG_ADDR), .RAM_BYTES(RAM_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rd_ram_o(rd_ram), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_ram_o(wr_ram), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .bulk_we_o(bulk_we), .bulk_data_o(bulk_data), .wp_i(wp), .time_i(time_bus), .snap_o(snap)
  );

  // storage model around the engine
  logic [7:0] mclk [0:CHG_ADDR];
  logic [7:0] mram [0:RAM_BYTES-1];
  logic       poke_en = 1'b0;
  logic [7:0] poke_val = 8'h00;
  int wr_cnt, bulk_cnt, snap_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= CHG_ADDR; k++) mclk[k] <= 8'h00;
      for (int k = 0; k < RAM_BYTES; k++) mram[k] <= 8'h00;
      wr_cnt <= 0; bulk_cnt <= 0; snap_cnt <= 0;
    end else begin
      if (wr_en) begin
        wr_cnt <= wr_cnt + 1;
        if (wr_ram) begin
          if (int'(wr_addr) < RAM_BYTES) mram[wr_addr] <= wr_data;
        end else if (int'(wr_addr) <= CHG_ADDR) mclk[wr_addr] <= wr_data;
      end
      if (bulk_we) begin
        bulk_cnt <= bulk_cnt + 1;
        for (int k = 0; k < CLK_REGS; k++) mclk[k] <= bulk_data[k*8 +: 8];
      end
      if (snap) snap_cnt <= snap_cnt + 1;
      if (poke_en) mclk[0] <= poke_val;
    end
  end

  // unstored addresses answer with a marker so gating is visible
  always_comb begin
    rd_data = 8'hEE;
    if (rd_ram) begin
      if (int'(rd_addr) < RAM_BYTES) rd_data = mram[rd_addr];
    end else if (int'(rd_addr) <= CHG_ADDR) rd_data = mclk[rd_addr];
  end
  assign wp = mclk[7][7];
  always_comb for (int k = 0; k < CLK_REGS-1; k++) time_bus[k*8 +: 8] = mclk[k];

  int n_tests = 0, n_fail = 0;
  logic oe_lo_s, oe_hi_s;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic o);
    sdi = b;
    repeat (H) @(negedge clk);
    o = sdo; oe_lo_s = sdo_oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    oe_hi_s = sdo_oe;
    sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 0; i < 8; i++) begin
      logic o;
      sbit(b[i], o);
      r[i] = o;
    end
  endtask

  task automatic open_x();
    sel = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic close_x();
    repeat (H) @(negedge clk);
    sel = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [7:0] d);
    logic [7:0] r;
    open_x(); xbyte(cmd, r); xbyte(d, r); close_x();
  endtask

  task automatic do_read(input logic [7:0] cmd, output logic [7:0] d);
    logic [7:0] r;
    open_x(); xbyte(cmd, r); xbyte(8'h00, d); close_x();
  endtask

  // {write cmd, write data, read cmd, expected read}
  localparam logic [31:0] VEC [7] = '{
    32'h80_45_81_45, 32'h8A_03_8B_03, 32'h90_A5_91_A5, 32'hC0_5A_C1_5A,
    32'hFC_3C_FD_3C, 32'h98_77_99_00, 32'h02_11_83_00
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, r2;
    int w0, b0, s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk("R1 reset oe", {31'd0, sdo_oe}, 0);
    chk("R1 reset strobes", {29'd0, wr_en, bulk_we, snap}, 0);

    // table of single-byte accesses
    for (int v = 0; v < 7; v++) begin
      do_write(VEC[v][31:24], VEC[v][23:16]);
      do_read(VEC[v][15:8], r);
      chk(v == 5 ? "R12 unstored clock addr" : (v == 6 ? "R2 bit7 clear blocks write" : "R2 R4 single access"),
          {24'd0, r}, {24'd0, VEC[v][7:0]});
    end

    // R5 repeat read and R3 output-enable timing
    open_x(); xbyte(8'h81, r); xbyte(8'h00, r);
    chk("R3 oe before rise", {31'd0, oe_lo_s}, 1);
    chk("R3 oe after rise", {31'd0, oe_hi_s}, 0);
    xbyte(8'h00, r2); close_x();
    chk("R5 first byte", {24'd0, r}, 32'h45);
    chk("R5 repeated byte", {24'd0, r2}, 32'h45);

    // R5 extra clocks after single write
    w0 = wr_cnt;
    open_x(); xbyte(8'h82, r); xbyte(8'h12, r); xbyte(8'hFF, r); close_x();
    chk("R5 one write", wr_cnt - w0, 1);
    do_read(8'h83, r);
    chk("R5 extra clocks ignored", {24'd0, r}, 32'h12);

    // R1 abort a write mid-byte
    w0 = wr_cnt;
    open_x(); xbyte(8'h84, r);
    for (int i = 0; i < 4; i++) begin logic o; sbit(1'b1, o); end
    sel = 1'b0; repeat (2*H) @(negedge clk);
    chk("R1 abort no write", wr_cnt - w0, 0);
    do_read(8'h85, r);
    chk("R1 abort reg unchanged", {24'd0, r}, 0);

    // R1 abort a read releases the line
    open_x(); xbyte(8'h81, r);
    for (int i = 0; i < 3; i++) begin logic o; sbit(1'b0, o); end
    sel = 1'b0; repeat (2) @(negedge clk);
    chk("R1 line released", {31'd0, sdo_oe}, 0);
    repeat (2*H) @(negedge clk);

    // R7 short clock burst is discarded
    b0 = bulk_cnt;
    open_x(); xbyte(8'hBE, r);
    for (int i = 0; i < 7; i++) xbyte(8'h11, r);
    close_x();
    chk("R7 short burst no commit", bulk_cnt - b0, 0);
    chk("R7 short burst reg0", {24'd0, mclk[0]}, 32'h45);

    // R7 full clock burst plus an extra byte, R11 charger untouched
    b0 = bulk_cnt; w0 = wr_cnt;
    open_x(); xbyte(8'hBE, r);
    xbyte(8'h30, r); xbyte(8'h59, r); xbyte(8'h23, r); xbyte(8'h28, r);
    xbyte(8'h02, r); xbyte(8'h04, r); xbyte(8'h24, r); xbyte(8'h00, r);
    xbyte(8'hEE, r);
    close_x();
    chk("R7 one commit", bulk_cnt - b0, 1);
    chk("R7 no single writes", wr_cnt - w0, 0);
    chk("R7 reg0", {24'd0, mclk[0]}, 32'h30);
    chk("R7 R6 reg6", {24'd0, mclk[6]}, 32'h24);
    chk("R11 charger kept", {24'd0, mclk[8]}, 32'hA5);

    // R10 burst read returns the captured time
    s0 = snap_cnt;
    open_x(); xbyte(8'hBF, r);
    @(negedge clk); poke_val = 8'h31; poke_en = 1'b1;
    @(negedge clk); poke_en = 1'b0;
    xbyte(8'h00, r);
    chk("R10 R6 byte0 from capture", {24'd0, r}, 32'h30);
    xbyte(8'h00, r);
    chk("R10 byte1", {24'd0, r}, 32'h59);
    for (int i = 2; i < 7; i++) xbyte(8'h00, r);
    chk("R10 byte6", {24'd0, r}, 32'h24);
    xbyte(8'h00, r);
    chk("R10 byte7 control", {24'd0, r}, 32'h00);
    xbyte(8'h00, r);
    chk("R11 ninth burst byte", {24'd0, r}, 32'h00);
    close_x();
    chk("R10 one snapshot", snap_cnt - s0, 1);
    chk("R10 live reg changed", {24'd0, mclk[0]}, 32'h31);

    // R8 short RAM burst
    w0 = wr_cnt;
    open_x(); xbyte(8'hFE, r); xbyte(8'hA1, r); xbyte(8'hA2, r); xbyte(8'hA3, r); close_x();
    chk("R8 three writes", wr_cnt - w0, 3);
    chk("R8 ram0", {24'd0, mram[0]}, 32'hA1);
    chk("R8 ram2", {24'd0, mram[2]}, 32'hA3);
    chk("R8 ram3 untouched", {24'd0, mram[3]}, 32'h00);

    // R8 overlong RAM burst, R12 RAM 31 reads zero
    w0 = wr_cnt;
    open_x(); xbyte(8'hFE, r);
    for (int i = 0; i < 33; i++) xbyte(8'(8'h40 + i), r);
    close_x();
    chk("R8 capped at 31", wr_cnt - w0, 31);
    chk("R8 ram30", {24'd0, mram[30]}, 32'h5E);
    open_x(); xbyte(8'hFF, r);
    xbyte(8'h00, r);
    chk("R6 RAM burst byte0", {24'd0, r}, 32'h40);
    for (int i = 1; i < 31; i++) xbyte(8'h00, r);
    chk("R8 RAM burst byte30", {24'd0, r}, 32'h5E);
    xbyte(8'h00, r);
    chk("R12 RAM addr31 zero", {24'd0, r}, 32'h00);
    close_x();

    // R9 write protect
    do_write(8'h8E, 8'h80);
    chk("R9 control writable", {24'd0, mclk[7]}, 32'h80);
    do_write(8'h80, 8'h99);
    chk("R9 clock reg blocked", {24'd0, mclk[0]}, 32'h31);
    do_write(8'hC2, 8'h77);
    chk("R9 RAM blocked", {24'd0, mram[1]}, 32'h41);
    b0 = bulk_cnt;
    open_x(); xbyte(8'hBE, r);
    for (int i = 0; i < 8; i++) xbyte(8'h00, r);
    close_x();
    chk("R9 burst blocked", bulk_cnt - b0, 0);
    chk("R9 burst left control", {24'd0, mclk[7]}, 32'h80);
    do_write(8'h8E, 8'h00);
    do_write(8'h80, 8'h99);
    chk("R9 writes resume", {24'd0, mclk[0]}, 32'h99);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule